// File: doc/BRIEF.md
# DS1 Payload Two-Lane Splitter and Combiner

This block carries a DS1 payload over two half-rate lanes. On the transmit side it takes the serial DS1 stream one bit per qualified clock, together with a strobe that marks the framing bit. It deals the 24 eight-bit time slots of each 193-bit frame onto two byte-wide lanes. The framing bit is copied onto both lanes, so either lane alone still carries frame timing. A mode input, sampled once per frame, selects how the slots are dealt: interleaved (odd and even slots) or block (first half and second half).

On the receive side a combiner collects one frame's worth of bytes from each lane. It puts the slots back into their original order under the same rule and plays the 193 bits out serially. It can also run with one lane declared down. The missing half of the payload is then replaced with idle code, and the framing bit is taken from the lane that is still alive. Frame alignment search, multiframe handling and line coding all belong to neighbouring blocks.

Top module: `ds1_dual_lane`

## Requirements
- R1: When `tx_bit_vld` and `tx_frm_start` are both high at a clock edge, both lanes show a beat one cycle later with `tx_lane_sof` high and a data byte whose bit 0 is the framing bit and whose upper bits are 0.
- R2: With mode 0 (interleaved), odd time slots (1, 3, ... 23) go to lane 0 and even time slots go to lane 1. A slot's first received bit is byte bit 7. The byte appears one cycle after the edge that samples the slot's eighth bit.
- R3: With mode 1 (block), slots 1 to 12 go to lane 0 and slots 13 to 24 go to lane 1, with the same bit order and timing as R2.
- R4: Per frame, each lane carries exactly 13 beats: the framing beat, then its 12 slot bytes in ascending slot order. Outside framing beats at most one lane is valid in any cycle.
- R5: The mode input is sampled only at the framing bit. A change in the middle of a frame takes effect from the next frame on.
- R6: Edges with `tx_bit_vld` low are ignored, including any `tx_frm_start` on them. Once 192 payload bits have followed a framing bit, further valid bits produce no lane output until the next framing bit.
- R7: With both lanes up and `rx_mode` equal to the mode used on transmit, the combiner outputs each frame as 193 consecutive `rx_vld` cycles. `rx_fs` is high on the first of them (the framing bit), and the slots follow in original order, MSB first. The combiner samples `rx_mode` at the lane framing beat.
- R8: If exactly one bit of `rx_lane_down` is set, every slot that belongs to that lane is output as 0xFF. The framing bit comes from the live lane, and any activity on the down lane's inputs has no effect.
- R9: With both lanes down, the combiner produces no output.
- R10: After reset no lane beat and no serial output bit is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_bit_vld | input | 1 | Qualifies `tx_bit` and `tx_frm_start` at this edge |
| tx_bit | input | 1 | Serial DS1 bit |
| tx_frm_start | input | 1 | Marks the framing bit |
| tx_mode | input | 1 | Allocation rule: 0 interleaved, 1 block |
| tx_lane_vld | output | 2 | Per-lane beat valid |
| tx_lane_sof | output | 2 | Per-lane framing beat flag |
| tx_lane_data | output | 2x8 | Per-lane byte |
| rx_lane_vld | input | 2 | Received per-lane beat valid |
| rx_lane_sof | input | 2 | Received per-lane framing flag |
| rx_lane_data | input | 2x8 | Received per-lane byte |
| rx_lane_down | input | 2 | Lane declared failed |
| rx_mode | input | 1 | Allocation rule for reassembly |
| rx_vld | output | 1 | Serial output bit valid |
| rx_bit | output | 1 | Rebuilt DS1 bit |
| rx_fs | output | 1 | High on the rebuilt framing bit |

## Verification
On every cycle the assertions check four things. The framing beat lands on both lanes with identical data, and payload beats never hit both lanes at once. Each serial output run lasts exactly one frame with its start flag first. A fully failed pair stays silent. Slot placement under each rule, mode sampling only at frame boundaries, idle fill for a failed lane and the rejection of junk on that lane all depend on frame contents. Only the bench's scenarios show those, using a behavioural model that follows every bit end to end.

// File: rtl/ds1_split_pkg.sv
package ds1_split_pkg;
  localparam int DS1_SLOTS  = 24;
  localparam int DS1_SLOT_W = 8;
  localparam int NUM_LANES  = 2;

  typedef enum logic {ALLOC_INTERLEAVE = 1'b0, ALLOC_BLOCK = 1'b1} alloc_e;

  // lane that owns zero-based slot s
  function automatic int slot_lane(input int s, input logic blk, input int nslots);
    if (blk) return (s >= nslots / 2) ? 1 : 0;
    return s % 2;
  endfunction

  // position of zero-based slot s within its lane
  function automatic int slot_pos(input int s, input logic blk, input int nslots);
    if (blk) return s % (nslots / 2);
    return s / 2;
  endfunction
endpackage

// File: rtl/ds1_splitter.sv
module ds1_splitter
  import ds1_split_pkg::*;
#(
  parameter int SLOTS  = DS1_SLOTS,
  parameter int SLOT_W = DS1_SLOT_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bit_vld,
  input  logic                   bit_in,
  input  logic                   frm_start,
  input  logic                   mode_in,
  output logic [1:0]             lane_vld,
  output logic [1:0]             lane_sof,
  output logic [1:0][SLOT_W-1:0] lane_data
);
  localparam int PAY_BITS = SLOTS * SLOT_W;
  localparam int CNT_W    = $clog2(PAY_BITS + 1);

  logic              synced;
  logic [CNT_W-1:0]  bit_cnt;
  logic [SLOT_W-2:0] shreg;
  logic              mode_q;

  logic              start_evt, pay_evt, slot_done, last_bit, dest_lane;
  logic [SLOT_W-1:0] byte_out;
  int                slot_idx, bit_ofs;

  always_comb begin
    start_evt = bit_vld & frm_start;
    pay_evt   = bit_vld & ~frm_start & synced;
    slot_idx  = int'(bit_cnt) / SLOT_W;
    bit_ofs   = int'(bit_cnt) % SLOT_W;
    slot_done = pay_evt && (bit_ofs == SLOT_W - 1);
    last_bit  = pay_evt && (bit_cnt == CNT_W'(PAY_BITS - 1));
    dest_lane = 1'(slot_lane(slot_idx, mode_q, SLOTS));
    byte_out  = {shreg, bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synced    <= 1'b0;
      bit_cnt   <= '0;
      shreg     <= '0;
      mode_q    <= 1'b0;
      lane_vld  <= '0;
      lane_sof  <= '0;
      lane_data <= '0;
    end else begin
      lane_vld <= '0;
      lane_sof <= '0;
      if (start_evt) begin
        synced   <= 1'b1;
        bit_cnt  <= '0;
        mode_q   <= mode_in;
        lane_vld <= '1;
        lane_sof <= '1;
        for (int l = 0; l < NUM_LANES; l++) lane_data[l] <= SLOT_W'(bit_in);
      end else if (pay_evt) begin
        shreg   <= {shreg[SLOT_W-3:0], bit_in};
        bit_cnt <= bit_cnt + CNT_W'(1);
        if (last_bit) synced <= 1'b0;
        if (slot_done) begin
          lane_vld[dest_lane]  <= 1'b1;
          lane_data[dest_lane] <= byte_out;
        end
      end
    end
  end

  // R1
  f_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (&lane_sof) && (&lane_vld) && (lane_data[0] == lane_data[1])
                  && (lane_data[0] == SLOT_W'($past(bit_in))));
  // R4
  single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_sof == '0) |-> $onehot0(lane_vld));
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!synced && !start_evt) |=> (lane_vld == '0));
endmodule

// File: rtl/ds1_lane_collector.sv
module ds1_lane_collector #(
  parameter int SPL    = 12,
  parameter int SLOT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     vld,
  input  logic                     sof,
  input  logic [SLOT_W-1:0]        data,
  input  logic                     down,
  input  logic                     clear,
  output logic [SPL-1:0][SLOT_W-1:0] slots,
  output logic                     fbit,
  output logic                     done
);
  localparam int POS_W = $clog2(SPL);

  logic             capturing;
  logic [POS_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slots     <= '0;
      fbit      <= 1'b0;
      done      <= 1'b0;
      capturing <= 1'b0;
      cnt       <= '0;
    end else begin
      if (clear) done <= 1'b0;
      if (down) begin
        capturing <= 1'b0;
        done      <= 1'b0;
      end else if (vld) begin
        if (sof) begin
          fbit      <= data[0];
          cnt       <= '0;
          capturing <= 1'b1;
          done      <= 1'b0;
        end else if (capturing) begin
          slots[cnt] <= data;
          cnt        <= cnt + POS_W'(1);
          if (cnt == POS_W'(SPL - 1)) begin
            capturing <= 1'b0;
            done      <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ds1_frame_serializer.sv
module ds1_frame_serializer #(
  parameter int FB = 193
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FB-1:0] frame,
  output logic          out_vld,
  output logic          out_bit,
  output logic          out_fs
);
  localparam int LW = $clog2(FB + 1);

  logic [FB-1:0] sh;
  logic [LW-1:0] left;
  logic [LW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      left    <= '0;
      out_vld <= 1'b0;
      out_bit <= 1'b0;
      out_fs  <= 1'b0;
    end else begin
      out_fs <= 1'b0;
      if (load) begin
        sh      <= {frame[FB-2:0], 1'b0};
        out_bit <= frame[FB-1];
        out_fs  <= 1'b1;
        out_vld <= 1'b1;
        left    <= LW'(FB - 1);
      end else if (left != '0) begin
        out_bit <= sh[FB-1];
        sh      <= {sh[FB-2:0], 1'b0};
        left    <= left - LW'(1);
        out_vld <= 1'b1;
      end else begin
        out_vld <= 1'b0;
      end
    end
  end

  // run length observer for the checks below
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_cnt <= '0;
    else if (out_fs)  run_cnt <= LW'(1);
    else if (out_vld) run_cnt <= run_cnt + LW'(1);
  end

  // R7
  fs_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fs |-> out_vld);
  // R7
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_vld) |-> (run_cnt == LW'(FB)));
endmodule

// File: rtl/ds1_combiner.sv
module ds1_combiner
  import ds1_split_pkg::*;
#(
  parameter int SLOTS  = DS1_SLOTS,
  parameter int SLOT_W = DS1_SLOT_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             ln_vld,
  input  logic [1:0]             ln_sof,
  input  logic [1:0][SLOT_W-1:0] ln_data,
  input  logic [1:0]             lane_down,
  input  logic                   mode_in,
  output logic                   out_vld,
  output logic                   out_bit,
  output logic                   out_fs
);
  localparam int SPL   = SLOTS / 2;
  localparam int POS_W = $clog2(SPL);
  localparam int FB    = 1 + SLOTS * SLOT_W;

  logic [1:0][SPL-1:0][SLOT_W-1:0] col_slots;
  logic [1:0]                      col_f, col_done;
  logic                            mode_c, all_down, load;
  logic [FB-1:0]                   frame;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    ds1_lane_collector #(.SPL(SPL), .SLOT_W(SLOT_W)) u_col (
      .clk  (clk),
      .rst_n(rst_n),
      .vld  (ln_vld[l]),
      .sof  (ln_sof[l]),
      .data (ln_data[l]),
      .down (lane_down[l]),
      .clear(load),
      .slots(col_slots[l]),
      .fbit (col_f[l]),
      .done (col_done[l])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_c <= 1'b0;
    else if (|(ln_vld & ln_sof & ~lane_down)) mode_c <= mode_in;
  end

  always_comb begin
    all_down = &lane_down;
    load     = !all_down && (&(col_done | lane_down));
  end

  always_comb begin
    logic             ln;
    logic [POS_W-1:0] ps;
    frame = '0;
    frame[FB-1] = lane_down[0] ? col_f[1] : col_f[0];
    for (int s = 0; s < SLOTS; s++) begin
      ln = 1'(slot_lane(s, mode_c, SLOTS));
      ps = POS_W'(slot_pos(s, mode_c, SLOTS));
      frame[FB-2-s*SLOT_W -: SLOT_W] = lane_down[ln] ? {SLOT_W{1'b1}} : col_slots[ln][ps];
    end
  end

  ds1_frame_serializer #(.FB(FB)) u_ser (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .frame  (frame),
    .out_vld(out_vld),
    .out_bit(out_bit),
    .out_fs (out_fs)
  );

  // R7
  load_to_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_fs && (out_bit == $past(frame[FB-1])));
  // R9
  both_down_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(&lane_down) |-> !out_fs);
endmodule

// File: rtl/ds1_dual_lane.sv
module ds1_dual_lane
  import ds1_split_pkg::*;
#(
  parameter int SLOTS  = DS1_SLOTS,
  parameter int SLOT_W = DS1_SLOT_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tx_bit_vld,
  input  logic                   tx_bit,
  input  logic                   tx_frm_start,
  input  logic                   tx_mode,
  output logic [1:0]             tx_lane_vld,
  output logic [1:0]             tx_lane_sof,
  output logic [1:0][SLOT_W-1:0] tx_lane_data,
  input  logic [1:0]             rx_lane_vld,
  input  logic [1:0]             rx_lane_sof,
  input  logic [1:0][SLOT_W-1:0] rx_lane_data,
  input  logic [1:0]             rx_lane_down,
  input  logic                   rx_mode,
  output logic                   rx_vld,
  output logic                   rx_bit,
  output logic                   rx_fs
);
  ds1_splitter #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_split (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_vld  (tx_bit_vld),
    .bit_in   (tx_bit),
    .frm_start(tx_frm_start),
    .mode_in  (tx_mode),
    .lane_vld (tx_lane_vld),
    .lane_sof (tx_lane_sof),
    .lane_data(tx_lane_data)
  );

  ds1_combiner #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_comb (
    .clk      (clk),
    .rst_n    (rst_n),
    .ln_vld   (rx_lane_vld),
    .ln_sof   (rx_lane_sof),
    .ln_data  (rx_lane_data),
    .lane_down(rx_lane_down),
    .mode_in  (rx_mode),
    .out_vld  (rx_vld),
    .out_bit  (rx_bit),
    .out_fs   (rx_fs)
  );
endmodule

// File: tb/ds1_dual_lane_bench.sv
module ds1_dual_lane_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_bit_vld = 1'b0, tx_bit = 1'b0, tx_frm_start = 1'b0, mode = 1'b0;
  logic [1:0] tx_lane_vld, tx_lane_sof;
  logic [1:0][7:0] tx_lane_data;
  logic [1:0] rx_lane_vld, rx_lane_sof, down = 2'b00;
  logic [1:0][7:0] rx_lane_data;
  logic [1:0] junk_vld = 2'b00, junk_sof = 2'b00;
  logic [1:0][7:0] junk_data = '0;
  logic rx_vld, rx_bit, rx_fs;

  int checks = 0, failures = 0;
  string scen = "R10";

  always #4 clk = ~clk;

  always_comb begin
    for (int l = 0; l < 2; l++) begin
      rx_lane_vld[l]  = down[l] ? junk_vld[l]  : tx_lane_vld[l];
      rx_lane_sof[l]  = down[l] ? junk_sof[l]  : tx_lane_sof[l];
      rx_lane_data[l] = down[l] ? junk_data[l] : tx_lane_data[l];
    end
  end

  ds1_dual_lane u_ds1_dual_lane (
    .clk(clk), .rst_n(rst_n),
    .tx_bit_vld(tx_bit_vld), .tx_bit(tx_bit), .tx_frm_start(tx_frm_start), .tx_mode(mode),
    .tx_lane_vld(tx_lane_vld), .tx_lane_sof(tx_lane_sof), .tx_lane_data(tx_lane_data),
    .rx_lane_vld(rx_lane_vld), .rx_lane_sof(rx_lane_sof), .rx_lane_data(rx_lane_data),
    .rx_lane_down(down), .rx_mode(mode),
    .rx_vld(rx_vld), .rx_bit(rx_bit), .rx_fs(rx_fs)
  );

  // reference model state
  bit m_sync = 0, m_mode = 0, m_f = 0;
  int m_cnt = 0, m_acc = 0;
  int m_slot[24];
  int act_cnt[2];
  bit exp_b[$], exp_f[$], act_b[$], act_f[$];

  // junk on failed lanes, and capture of serial output
  always @(negedge clk) begin
    junk_vld  <= 2'($urandom);
    junk_sof  <= 2'($urandom);
    junk_data <= 16'($urandom);
    if (rst_n && rx_vld) begin
      act_b.push_back(rx_bit);
      act_f.push_back(rx_fs);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s (%s) actual=%0h expected=%0h t=%0t", req, scen, act, exp, $time);
    end
  endtask

  task automatic compare_stream();
    while (exp_b.size() > 0 && act_b.size() > 0) begin
      bit eb = exp_b.pop_front(), ef = exp_f.pop_front();
      bit ab = act_b.pop_front(), af = act_f.pop_front();
      check(ab == eb && af == ef, (down != 0) ? ((down == 2'b11) ? "R9" : "R8") : "R7",
            {af, ab}, {ef, eb});
    end
  endtask

  task automatic push_expected();
    if (down == 2'b11) return;
    exp_b.push_back(m_f); exp_f.push_back(1'b1);
    for (int s = 1; s <= 24; s++) begin
      int ln = m_mode ? (s > 12) : (s % 2 == 0);
      int by = down[ln] ? 8'hFF : m_slot[s-1];
      for (int k = 7; k >= 0; k--) begin
        exp_b.push_back(by[k]); exp_f.push_back(1'b0);
      end
    end
  endtask

  task automatic step(input bit v, input bit b, input bit fs);
    bit [1:0] ev = 0, es = 0;
    int ed[2];
    bit was_sync = m_sync, frame_end = 0;
    string tag;
    tx_bit_vld = v; tx_bit = b; tx_frm_start = fs;
    @(posedge clk);
    @(negedge clk);
    ed[0] = 0; ed[1] = 0;
    if (v && fs) begin
      m_sync = 1; m_cnt = 0; m_mode = mode; m_f = b;
      ev = 2'b11; es = 2'b11; ed[0] = b; ed[1] = b;
      act_cnt[0] = 0; act_cnt[1] = 0;
    end else if (v && m_sync) begin
      m_acc = ((m_acc << 1) | b) & 8'hFF;
      m_cnt++;
      if (m_cnt % 8 == 0) begin
        int sl = m_cnt / 8;
        int ln = m_mode ? (sl > 12) : (sl % 2 == 0);
        ev[ln] = 1; ed[ln] = m_acc; m_slot[sl-1] = m_acc;
      end
      if (m_cnt == 192) begin m_sync = 0; frame_end = 1; end
    end
    tag = (es != 0) ? "R1" : (!was_sync ? "R6" : (m_mode ? "R3" : "R2"));
    for (int l = 0; l < 2; l++) begin
      bit ok = (tx_lane_vld[l] == ev[l]) && (tx_lane_sof[l] == es[l]) &&
               (!ev[l] || tx_lane_data[l] == 8'(ed[l]));
      check(ok, tag, {tx_lane_vld[l], tx_lane_sof[l], tx_lane_data[l]},
            {ev[l], es[l], 8'(ed[l])});
      act_cnt[l] += int'(tx_lane_vld[l]);
    end
    if (frame_end) begin
      for (int l = 0; l < 2; l++) check(act_cnt[l] == 13, "R4", act_cnt[l], 13);
      push_expected();
    end
    compare_stream();
  endtask

  task automatic send_frame(input int gap_pct, input int chg_at, input bit new_mode);
    step(1'b1, 1'($urandom), 1'b1);
    for (int i = 0; i < 192; i++) begin
      while (int'($urandom % 100) < gap_pct) step(1'b0, 1'($urandom), 1'($urandom));
      if (i == chg_at) mode = new_mode;
      step(1'b1, 1'($urandom), 1'b0);
    end
  endtask

  task automatic flush();
    for (int i = 0; i < 420; i++) step(1'b0, 1'b0, 1'b0);
    compare_stream();
    check(exp_b.size() == 0 && act_b.size() == 0,
          (down == 2'b11) ? "R9" : ((down != 0) ? "R8" : "R7"), act_b.size(), exp_b.size());
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: quiet during and after reset
    check(tx_lane_vld == 0 && rx_vld == 0, "R10", {tx_lane_vld, rx_vld}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_lane_vld == 0 && rx_vld == 0, "R10", {tx_lane_vld, rx_vld}, 0);

    scen = "R2"; mode = 1'b0;
    repeat (3) send_frame(0, -1, 1'b0);
    flush();

    scen = "R3"; mode = 1'b1;
    repeat (3) send_frame(0, -1, 1'b1);
    flush();

    scen = "R5"; mode = 1'b0;
    send_frame(0, 100, 1'b1);
    send_frame(0, 50, 1'b0);
    send_frame(0, -1, 1'b0);
    flush();

    scen = "R6"; mode = 1'b1;
    send_frame(30, -1, 1'b1);
    send_frame(30, -1, 1'b1);
    for (int i = 0; i < 20; i++) step(1'b1, 1'($urandom), 1'b0);
    flush();

    scen = "R8"; down = 2'b10; mode = 1'b0;
    repeat (2) send_frame(0, -1, 1'b0);
    flush();
    mode = 1'b1;
    repeat (2) send_frame(0, -1, 1'b1);
    flush();
    down = 2'b01;
    repeat (2) send_frame(0, -1, 1'b1);
    flush();
    mode = 1'b0;
    repeat (2) send_frame(10, -1, 1'b0);
    flush();

    scen = "R9"; down = 2'b11;
    repeat (2) send_frame(0, -1, 1'b0);
    flush();

    scen = "R7"; down = 2'b00; mode = 1'b1;
    repeat (2) send_frame(5, -1, 1'b1);
    flush();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog (%s) actual=expired expected=done", scen);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule